// File: doc/BRIEF.md
# Serial Flash Fast-Read Controller

This controller streams bytes out of a serial NOR flash over a single-bit link using the fast-read command. A user-side request is a start strobe and a read-enable level, sampled together on a rising clock edge, plus a byte address. The controller then lowers chip select and shifts out the opcode 0x0B, the address and eight dummy bits. After that it shifts in data, one bit per system clock. Each completed byte appears on the data output with a one-cycle valid pulse and with the flash address it came from.

The length of a burst is not programmed. The burst keeps running while read-enable stays high. Once read-enable has been seen low, the controller delivers exactly one more byte, or the first byte if none has been delivered yet. It then releases the flash and clears busy. After busy clears there is a fixed two-cycle recovery gap before a new request is taken.

The state machine has five states. IDLE goes to CMD on an accepted request. CMD goes to DATA after the last dummy bit. DATA loops on itself once per byte while the burst continues, and goes to FINISH when the final byte completes. FINISH, the cycle in which the final valid pulse is shown, goes to GAP. GAP goes back to IDLE after two cycles. A parameter widens the address from 24 to 32 bits.

Top module: `sflash_fastread_ctrl`

## Requirements
- R1: In IDLE, a request is accepted only at a rising edge where `start_i` and `rden_i` are both high. `start_i` without `rden_i` is ignored. `busy_o` is high from the cycle after the accepting edge.
- R2: From the cycle after acceptance, `cs_n_o` is low and `mosi_o` carries 8'h0B, then the address, then eight zero dummy bits, each MSB first, one bit per clock. `mosi_o` changes on the rising clock edge, and `sck_o` rises in the middle of each bit.
- R3: The first valid pulse is seen in the cycle after edge 16+ADDR_W+8 counted from the accepting edge (edge 0). For 24-bit addressing that is edge 48.
- R4: `valid_o` is high for exactly one cycle per byte. Later bytes in a burst follow every 8 cycles. Each byte is assembled MSB first from `miso_i`, sampled on rising clock edges.
- R5: `rd_addr_o` shows the address of the byte on `data_o`. It starts at the requested address and increases by one per byte, wrapping modulo 2^ADDR_W.
- R6: If `rden_i` is lowered in the cycle where byte k is valid (k ≥ 1, with earlier bytes having `rden_i` high), exactly k+1 bytes are delivered.
- R7: If `rden_i` is high only in the start cycle, or falls at any point before the first valid pulse, exactly one byte is delivered.
- R8: `busy_o` stays high through the cycle of the final valid pulse and is low in the next cycle. `cs_n_o` is high again by the final valid cycle.
- R9: `data_o` and `rd_addr_o` keep their last values until a new byte is delivered or reset is applied.
- R10: A request presented to the first or second rising edge after `busy_o` has been seen low is ignored. The third such edge accepts it.
- R11: Under reset, `busy_o` and `valid_o` are low, `cs_n_o` is high, `sck_o` is low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled with `rden_i` |
| rden_i | input | 1 | Read-enable; held high to continue the burst |
| addr_i | input | ADDR_W | First byte address, stable at the start edge |
| busy_o | output | 1 | High while a command is in progress |
| valid_o | output | 1 | One-cycle pulse marking a new byte |
| data_o | output | 8 | Last byte read |
| rd_addr_o | output | ADDR_W | Address of the byte on `data_o` |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Flash serial clock |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
Several rules are checked on every cycle by the assertions. Valid is a single-cycle pulse. Data and read address change only with valid. Chip select is low only while busy. Idle stays idle without a full request. Busy stays low for two cycles after it falls. The bench scenarios cover what needs a reference flash model: the exact opcode, address and dummy bits on the serial line, the byte values and their addresses, the first-byte latency and the byte spacing. They also show how many bytes follow a read-enable drop at different points of a burst, and which edge ends the recovery gap.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_FINISH,
        ST_GAP
    } sfr_state_e;

    localparam logic [7:0] FAST_READ_OP = 8'h0B;
    localparam int         DUMMY_BITS   = 8;
    localparam int         GAP_CYCLES   = 2;
endpackage

// File: rtl/sfr_tx_shift.sv
// Parallel-load shift register feeding the serial output, MSB first.
module sfr_tx_shift #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic         bit_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr_q <= '0;
        else if (load)   sr_q <= load_val;
        else if (shift)  sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign bit_o = sr_q[W-1];
endmodule

// File: rtl/sfr_rx_shift.sv
// Serial-in byte assembler; byte_next is the byte including the bit now sampled.
module sfr_rx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bit_i,
    output logic [7:0] byte_next
);
    logic [6:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sr_q <= '0;
        else if (en)  sr_q <= {sr_q[5:0], bit_i};
    end

    assign byte_next = {sr_q, bit_i};
endmodule

// File: rtl/sflash_fastread_ctrl.sv
module sflash_fastread_ctrl
    import sfr_pkg::*;
#(
    parameter bit WIDE_ADDR = 1'b0,
    localparam int ADDR_W = WIDE_ADDR ? 32 : 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rden_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [7:0]        data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int CMD_BITS = 8 + ADDR_W + DUMMY_BITS;
    localparam int CNT_W    = $clog2(CMD_BITS);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYCLES - 1);

    sfr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              keep_q, keep_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;

    logic              accept;
    logic              byte_done;
    logic              link_on_d;
    logic              cs_n_q;
    logic              sck_gate_q;
    logic              valid_q;
    logic [7:0]        data_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [7:0]        rx_byte;

    assign accept    = (state_q == ST_IDLE) && start_i && rden_i;
    assign byte_done = (state_q == ST_DATA) && (cnt_q == '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        keep_d  = keep_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_CMD;
                    cnt_d   = CMD_LAST;
                    keep_d  = 1'b1;
                    ptr_d   = addr_i;
                end
            end
            ST_CMD: begin
                keep_d = keep_q & rden_i;
                if (cnt_q == '0) begin
                    state_d = ST_DATA;
                    cnt_d   = BIT_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DATA: begin
                keep_d = keep_q & rden_i;
                if (cnt_q == '0) begin
                    ptr_d = ptr_q + ADDR_W'(1);
                    if (keep_q && rden_i) cnt_d = BIT_LAST;
                    else                  state_d = ST_FINISH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_FINISH: begin
                state_d = ST_GAP;
                cnt_d   = GAP_LAST;
            end
            ST_GAP: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            keep_q  <= 1'b0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            keep_q  <= keep_d;
            ptr_q   <= ptr_d;
        end
    end

    // Registered outputs
    assign link_on_d = (state_d == ST_CMD) || (state_d == ST_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q     <= 1'b1;
            sck_gate_q <= 1'b0;
            valid_q    <= 1'b0;
            data_q     <= '0;
            rd_addr_q  <= '0;
        end else begin
            cs_n_q     <= !link_on_d;
            sck_gate_q <= link_on_d;
            valid_q    <= byte_done;
            if (byte_done) begin
                data_q    <= rx_byte;
                rd_addr_q <= ptr_q;
            end
        end
    end

    sfr_tx_shift #(.W(CMD_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (state_q == ST_CMD),
        .load_val ({FAST_READ_OP, addr_i, {DUMMY_BITS{1'b0}}}),
        .bit_o    (mosi_o)
    );

    sfr_rx_shift u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state_q == ST_DATA),
        .bit_i     (miso_i),
        .byte_next (rx_byte)
    );

    assign busy_o    = (state_q == ST_CMD) || (state_q == ST_DATA) || (state_q == ST_FINISH);
    assign valid_o   = valid_q;
    assign data_o    = data_q;
    assign rd_addr_o = rd_addr_q;
    assign cs_n_o    = cs_n_q;
    // Serial clock rises mid-bit; the gate only changes while clk is high.
    assign sck_o     = sck_gate_q & ~clk;
endmodule

// File: rtl/sfr_fastread_chk.sv
module sfr_fastread_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rden_i,
    input logic              busy_o,
    input logic              valid_o,
    input logic [7:0]        data_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              cs_n_o
);
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r8_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o);

    a_r8_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(rd_addr_o));

    a_r1_idle_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(start_i && rden_i)) |=> !busy_o);

    a_r10_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |=> !busy_o ##1 !busy_o);
endmodule

bind sflash_fastread_ctrl sfr_fastread_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rden_i    (rden_i),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .rd_addr_o (rd_addr_o),
    .cs_n_o    (cs_n_o)
);

// File: tb/tb_sflash_fastread_ctrl.sv
`timescale 1ns/1ps
module tb_sflash_fastread_ctrl;
    localparam int AW       = 24;
    localparam int CMDB     = 8 + AW + 8;
    localparam int FIRST_K  = CMDB + 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i, rden_i;
    logic [AW-1:0] addr_i;
    logic          busy_o, valid_o, cs_n_o, sck_o, mosi_o, miso_i;
    logic [7:0]    data_o;
    logic [AW-1:0] rd_addr_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sflash_fastread_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rden_i(rden_i),
        .addr_i(addr_i), .busy_o(busy_o), .valid_o(valid_o), .data_o(data_o),
        .rd_addr_o(rd_addr_o), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(miso_i)
    );

    function automatic logic [7:0] fmem(input logic [AW-1:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd13;
        return m ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // Flash model
    logic [CMDB-1:0] cap = '0;
    int fbit = 0;
    always @(negedge cs_n_o) fbit = 0;
    always @(posedge sck_o) if (!cs_n_o) begin
        if (fbit < CMDB) cap = {cap[CMDB-2:0], mosi_o};
        fbit++;
    end
    always @(negedge sck_o) if (!cs_n_o && fbit >= CMDB) begin
        automatic int off = fbit - CMDB;
        automatic logic [7:0] b = fmem(cap[AW+7:8] + AW'(off / 8));
        miso_i <= b[7 - (off % 8)];
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // One read; returns at the negedge klast+tail after the accepting edge.
    task automatic run_read(input logic [AW-1:0] a, input int n, input int drop_k, input int tail);
        int idx = 0;
        int busy_bad = 0;
        int klast = FIRST_K + 8 * (n - 1);
        logic [AW-1:0] ea;
        @(negedge clk);
        addr_i = a; start_i = 1'b1; rden_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= klast + tail; k++) begin
            if (k > 0) @(negedge clk);
            if (busy_o !== (k <= klast)) busy_bad++;
            if (valid_o) begin
                ea = a + AW'(idx);
                if (idx == 0) check(k == FIRST_K, "R3 first byte edge", k, FIRST_K);
                else          check(k == FIRST_K + 8 * idx, "R4 byte spacing", k, FIRST_K + 8 * idx);
                check(data_o == fmem(ea), "R4 data", data_o, fmem(ea));
                check(rd_addr_o == ea, "R5 read address", rd_addr_o, ea);
                idx++;
            end
            if ((n == 1 && k == drop_k) || (n > 1 && k == FIRST_K + 8 * (n - 2))) rden_i = 1'b0;
        end
        if (n == 1) check(idx == 1, "R7 single byte count", idx, 1);
        else        check(idx == n, "R6 burst byte count", idx, n);
        check(busy_bad == 0, "R8 busy window", busy_bad, 0);
        check(cap[CMDB-1:CMDB-8] == 8'h0B, "R2 opcode", cap[CMDB-1:CMDB-8], 8'h0B);
        check(cap[AW+7:8] == a, "R2 address bits", cap[AW+7:8], a);
        check(cap[7:0] == 8'h00, "R2 dummy bits", cap[7:0], 0);
        if (tail >= 1) check(cs_n_o == 1'b1, "R8 chip select released", cs_n_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [AW-1:0] addrs [4] = '{24'h000000, 24'h123456, 24'hFFFFFE, 24'h00FFFD};
        rst_n = 1'b0; start_i = 1'b0; rden_i = 1'b0; addr_i = '0; miso_i = 1'b0;
        repeat (3) @(negedge clk);
        check(busy_o == 0 && valid_o == 0, "R11 reset busy/valid", {busy_o, valid_o}, 0);
        check(cs_n_o == 1 && sck_o == 0, "R11 reset link", {cs_n_o, sck_o}, 2);
        check(data_o == 8'h00, "R11 reset data", data_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: start without read-enable is ignored
        start_i = 1'b1; rden_i = 1'b0; addr_i = 24'h55AA55;
        @(negedge clk); start_i = 1'b0;
        check(busy_o == 0, "R1 start without rden", busy_o, 0);
        @(negedge clk);
        check(cs_n_o == 1, "R1 link idle", cs_n_o, 1);

        // R6: burst length sweep over several addresses (incl. wrap)
        foreach (addrs[i]) for (int n = 1; n <= 5; n++) run_read(addrs[i], n, 0, 4);

        // R7: read-enable falls at various points before the first byte
        foreach (addrs[i]) begin
            run_read(addrs[i] + 24'd7, 1, 10, 4);
            run_read(addrs[i] + 24'd9, 1, 30, 4);
            run_read(addrs[i] + 24'd3, 1, FIRST_K - 1, 4);
        end

        // R9: outputs hold after the burst
        begin
            int bad = 0;
            run_read(24'hABCDEF, 3, 0, 4);
            start_i = 1'b1; rden_i = 1'b0;
            @(negedge clk); start_i = 1'b0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (data_o != fmem(24'hABCDF1) || rd_addr_o != 24'hABCDF1) bad++;
            end
            check(bad == 0, "R9 data/address hold", bad, 0);
        end

        // R10: recovery gap after busy clears
        for (int t = 1; t <= 3; t++) begin
            run_read(24'h0A0B00 + AW'(t), 1, 0, t);
            addr_i = 24'h3C0000 + AW'(t); start_i = 1'b1; rden_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; rden_i = 1'b0;
            check(busy_o == (t == 3), "R10 gap edge acceptance", busy_o, t == 3);
            if (t == 3) begin
                while (busy_o) @(negedge clk);
                check(data_o == fmem(24'h3C0003), "R10 accepted read data", data_o, fmem(24'h3C0003));
                repeat (4) @(negedge clk);
            end else begin
                @(negedge clk);
                check(busy_o == 0, "R10 still ignored", busy_o, 0);
                repeat (4) @(negedge clk);
            end
        end

        summary();
    end
endmodule